// File: doc/BRIEF.md
# Watermark-Driven Burst DMA Request Controller

This block sits between a data FIFO and a bus-mastering DMA engine. It watches how many words the FIFO holds and decides when the DMA engine should move a burst. In the receive direction (FIFO to memory), it asks for a burst once enough data has built up. In the transmit direction (memory to FIFO), it asks once enough room has opened up. A single 32-bit threshold word carries three fields: a burst-size code, a receive watermark and a transmit watermark.

Near the end of a transfer, fewer words may be left than one programmed burst. The controller then shortens the request to exactly the remaining words, so that the last few words still move even when the watermark would never trip. It also runs the FIFO pointer soft reset, which lasts a fixed number of cycles and then clears itself.

Control is a three-state machine:
- `ST_IDLE`: evaluates the request condition every cycle.
- `ST_REQ`: holds a request and its length until the DMA engine acknowledges it.
- `ST_FLUSH`: drives the FIFO pointer reset.

The transitions are:
- IDLE→REQ: the request condition is true.
- REQ→IDLE: acknowledge.
- IDLE→FLUSH and REQ→FLUSH: soft reset.
- FLUSH→FLUSH: the reset count is still running, or the soft reset is raised again.
- FLUSH→IDLE: the count has expired.

Top module: `wm_dma_req`

## Requirements
- R1: The burst code in `thr_cfg[30:28]` selects the programmed burst: 0→1, 1→4, 2→8, 3→16, 4→32, 5→64, 6→128, 7→256 words. A request that is not end-limited presents that length on `dma_len`.
- R2: With `dir_tx`=0 (receive), a request is raised when `fifo_count` is strictly greater than the receive watermark `thr_cfg[27:16]`. It is not raised when the count equals the watermark.
- R3: With `dir_tx`=1 (transmit), a request is raised when `fifo_count` is strictly less than the transmit watermark `thr_cfg[11:0]`. It is not raised when the count equals the watermark.
- R4: The remaining words are `ceil(bytes_left / 4)`. The request length is the smaller of the programmed burst and the remaining words. In the receive direction, a request is also raised when the remaining words are nonzero and `fifo_count` is at least the remaining words, even if the count is not above the watermark.
- R5: When `bytes_left` is 0, no request is raised in either direction.
- R6: Once raised, `dma_req` stays high and `dma_len` stays unchanged until `dma_ack` is sampled high.
- R7: On the clock edge that samples `dma_ack` high, `dma_req` drops for at least one cycle. The condition is evaluated again in that cycle, so `dma_req` can return on the following edge.
- R8: A watermark field at or above `fifo_depth` is treated as `fifo_depth`-1.
- R9: A sampled `fifo_soft_rst` drops any pending request and drives `fifo_ptr_rst` high for `RST_CYCLES` cycles. `fifo_ptr_rst` then clears by itself. No request is raised while it is high.
- R10: After `rst_n` is asserted, `dma_req` and `fifo_ptr_rst` are low and `dma_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | CW ($clog2(MAX_DEPTH+1)) | Words currently held in the FIFO |
| fifo_depth | input | CW | FIFO capacity in words |
| thr_cfg | input | 32 | [30:28] burst code, [27:16] receive watermark, [11:0] transmit watermark |
| dir_tx | input | 1 | 1 = transmit (fill FIFO), 0 = receive (drain FIFO) |
| bytes_left | input | BYTE_CNT_W | Bytes of the transfer not yet moved by DMA |
| fifo_soft_rst | input | 1 | Software request to reset the FIFO pointers |
| dma_ack | input | 1 | DMA engine accepts the pending burst |
| dma_req | output | 1 | Burst request |
| dma_len | output | 9 | Words in the requested burst |
| fifo_ptr_rst | output | 1 | FIFO pointer reset, self-clearing |

## Verification
Some properties are checked by assertions on every cycle:
- a raised request holds with a stable length until acknowledged;
- an acknowledge always opens a gap;
- no request coexists with the pointer reset;
- a soft reset always starts the pointer reset;
- a new request never asks for more words than remain;
- the effective watermarks stay below the depth.

Other behaviours are shown only by the bench scenarios:
- the exact burst decode;
- the strictness of both watermark comparisons, probed at the equal value;
- the receive tail flush, and the rounding of a partial word;
- the clamp of oversized watermarks;
- the length of the pointer reset, and the request that returns once it ends.

// File: rtl/wmdma_pkg.sv
package wmdma_pkg;

    localparam int BURST_LEN_W = 9;   // enough for 256
    localparam int WM_W        = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_FLUSH = 2'd2
    } wm_state_e;

    // Burst code to word count: 0 -> 1, n -> 2^(n+1)
    function automatic logic [BURST_LEN_W-1:0] burst_words(input logic [2:0] code);
        logic [3:0] sh;
        sh = {1'b0, code} + 4'd1;
        if (code == 3'd0)
            return BURST_LEN_W'(1);
        else
            return BURST_LEN_W'(1) << sh;
    endfunction

endpackage

// File: rtl/wm_thresholds.sv
module wm_thresholds
    import wmdma_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic [CW-1:0]          fifo_depth,
    input  logic [31:0]            thr_cfg,
    output logic [WM_W-1:0]        rx_wm_eff,
    output logic [WM_W-1:0]        tx_wm_eff,
    output logic [BURST_LEN_W-1:0] burst_len
);

    logic [WM_W-1:0] wm_raw [2];
    logic [WM_W-1:0] wm_eff [2];
    logic            unused_cfg_bits;

    assign wm_raw[0] = thr_cfg[27:16];
    assign wm_raw[1] = thr_cfg[11:0];
    assign unused_cfg_bits = ^{thr_cfg[31], thr_cfg[15:12]};

    // Same clamp on each watermark field
    for (genvar i = 0; i < 2; i++) begin : g_clamp
        always_comb begin
            if (32'(wm_raw[i]) >= 32'(fifo_depth))
                wm_eff[i] = WM_W'(fifo_depth - CW'(1));
            else
                wm_eff[i] = wm_raw[i];
        end
    end

    assign rx_wm_eff = wm_eff[0];
    assign tx_wm_eff = wm_eff[1];
    assign burst_len = burst_words(thr_cfg[30:28]);

endmodule

// File: rtl/wm_request_eval.sv
module wm_request_eval
    import wmdma_pkg::*;
#(
    parameter int CW         = 11,
    parameter int BYTE_CNT_W = 16,
    parameter int WORD_BYTES = 4,
    parameter int WW         = 15
) (
    input  logic [CW-1:0]          fifo_count,
    input  logic [WM_W-1:0]        rx_wm,
    input  logic [WM_W-1:0]        tx_wm,
    input  logic [BURST_LEN_W-1:0] burst_len,
    input  logic                   dir_tx,
    input  logic [BYTE_CNT_W-1:0]  bytes_left,
    output logic [WW-1:0]          words_left,
    output logic                   want,
    output logic [BURST_LEN_W-1:0] want_len
);

    localparam int SH = $clog2(WORD_BYTES);

    logic [BYTE_CNT_W:0] bytes_round;
    logic                has_left;
    logic                above_rx;
    logic                below_tx;
    logic                tail_fits;

    // Round up to whole words
    assign bytes_round = {1'b0, bytes_left} + (BYTE_CNT_W+1)'(WORD_BYTES - 1);
    assign words_left  = WW'(bytes_round >> SH);

    always_comb begin
        has_left  = (words_left != '0);
        above_rx  = 32'(fifo_count) > 32'(rx_wm);
        below_tx  = 32'(fifo_count) < 32'(tx_wm);
        tail_fits = 32'(fifo_count) >= 32'(words_left);
        if (dir_tx)
            want = has_left && below_tx;
        else
            want = has_left && (above_rx || tail_fits);
        if (32'(words_left) >= 32'(burst_len))
            want_len = burst_len;
        else
            want_len = BURST_LEN_W'(words_left);
    end

endmodule

// File: rtl/wm_dma_req.sv
module wm_dma_req
    import wmdma_pkg::*;
#(
    parameter int MAX_DEPTH  = 1024,
    parameter int BYTE_CNT_W = 16,
    parameter int WORD_BYTES = 4,
    parameter int RST_CYCLES = 2,
    localparam int CW        = $clog2(MAX_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          fifo_count,
    input  logic [CW-1:0]          fifo_depth,
    input  logic [31:0]            thr_cfg,
    input  logic                   dir_tx,
    input  logic [BYTE_CNT_W-1:0]  bytes_left,
    input  logic                   fifo_soft_rst,
    input  logic                   dma_ack,
    output logic                   dma_req,
    output logic [BURST_LEN_W-1:0] dma_len,
    output logic                   fifo_ptr_rst
);

    localparam int WW  = BYTE_CNT_W + 1 - $clog2(WORD_BYTES);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    wm_state_e              state_q, state_d;
    logic [RCW-1:0]         flush_cnt_q;
    logic [BURST_LEN_W-1:0] len_q;

    logic [WM_W-1:0]        rx_wm_eff;
    logic [WM_W-1:0]        tx_wm_eff;
    logic [BURST_LEN_W-1:0] burst_len;
    logic [WW-1:0]          words_left;
    logic                   want;
    logic [BURST_LEN_W-1:0] want_len;

    wm_thresholds #(.CW(CW)) u_thr (
        .fifo_depth (fifo_depth),
        .thr_cfg    (thr_cfg),
        .rx_wm_eff  (rx_wm_eff),
        .tx_wm_eff  (tx_wm_eff),
        .burst_len  (burst_len)
    );

    wm_request_eval #(
        .CW(CW), .BYTE_CNT_W(BYTE_CNT_W), .WORD_BYTES(WORD_BYTES), .WW(WW)
    ) u_eval (
        .fifo_count (fifo_count),
        .rx_wm      (rx_wm_eff),
        .tx_wm      (tx_wm_eff),
        .burst_len  (burst_len),
        .dir_tx     (dir_tx),
        .bytes_left (bytes_left),
        .words_left (words_left),
        .want       (want),
        .want_len   (want_len)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fifo_soft_rst)      state_d = ST_FLUSH;
                else if (want)          state_d = ST_REQ;
            end
            ST_REQ: begin
                if (fifo_soft_rst)      state_d = ST_FLUSH;
                else if (dma_ack)       state_d = ST_IDLE;
            end
            ST_FLUSH: begin
                if (fifo_soft_rst)      state_d = ST_FLUSH;
                else if (flush_cnt_q == '0) state_d = ST_IDLE;
            end
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register, flush counter and captured length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            flush_cnt_q <= '0;
            len_q       <= '0;
        end else begin
            state_q <= state_d;
            if (fifo_soft_rst)
                flush_cnt_q <= RCW'(RST_CYCLES - 1);
            else if (state_q == ST_FLUSH && flush_cnt_q != '0)
                flush_cnt_q <= flush_cnt_q - RCW'(1);
            if (state_q == ST_IDLE && state_d == ST_REQ)
                len_q <= want_len;
        end
    end

    // Outputs
    always_comb begin
        dma_req      = (state_q == ST_REQ);
        fifo_ptr_rst = (state_q == ST_FLUSH);
        dma_len      = len_q;
    end

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_len != '0 && 32'(dma_len) <= 256)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !fifo_soft_rst) |=> (dma_req && $stable(dma_len))); // R6

    AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req); // R7

    AST_TAIL_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> 32'(dma_len) <= 32'($past(words_left))); // R4

    AST_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && words_left == '0) |=> !dma_req); // R5

    AST_WM_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_depth != '0) |-> (32'(rx_wm_eff) < 32'(fifo_depth) &&
                                32'(tx_wm_eff) < 32'(fifo_depth))); // R8

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ptr_rst |-> !dma_req); // R9

    AST_SOFT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_soft_rst |=> fifo_ptr_rst); // R9

endmodule

// File: tb/tb_wm_dma_req.sv
`timescale 1ns/1ps
module tb_wm_dma_req;

    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] fifo_count;
    logic [CW-1:0] fifo_depth;
    logic [31:0]   thr_cfg;
    logic          dir_tx;
    logic [15:0]   bytes_left;
    logic          fifo_soft_rst;
    logic          dma_ack;
    logic          dma_req;
    logic [8:0]    dma_len;
    logic          fifo_ptr_rst;

    always #2.5 clk = ~clk;   // 200 MHz

    wm_dma_req dut (
        .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .fifo_depth(fifo_depth),
        .thr_cfg(thr_cfg), .dir_tx(dir_tx), .bytes_left(bytes_left),
        .fifo_soft_rst(fifo_soft_rst), .dma_ack(dma_ack),
        .dma_req(dma_req), .dma_len(dma_len), .fifo_ptr_rst(fifo_ptr_rst)
    );

    typedef struct {
        bit    req;
        int    len;
        bit    prst;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    // Monitor: compare the oldest expected item at each falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (dma_req !== e.req || fifo_ptr_rst !== e.prst ||
                (e.req && int'(dma_len) != e.len)) begin
                n_fail++;
                $display("FAIL %s: req=%0b len=%0d prst=%0b, expected req=%0b len=%0d prst=%0b",
                         e.tag, dma_req, dma_len, fifo_ptr_rst, e.req, e.len, e.prst);
            end
        end
    end

    // Driver side: wait one rising edge, push what the outputs must show
    task automatic chk(input bit req, input int len, input bit prst, input string tag);
        exp_t e;
        @(posedge clk);
        e.req = req; e.len = len; e.prst = prst; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic accept(input string tag);
        dma_ack = 1'b1;
        chk(0, 0, 0, tag);
        dma_ack = 1'b0;
    endtask

    function automatic logic [31:0] cfg(input int code, input int rxw, input int txw);
        return {1'b0, 3'(code), 12'(rxw), 4'b0, 12'(txw)};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fifo_count = 0; fifo_depth = 64; thr_cfg = cfg(1, 7, 8);
        dir_tx = 0; bytes_left = 400; fifo_soft_rst = 0; dma_ack = 0;
        @(negedge clk);
        chk(0, 0, 0, "R10 reset state");
        if (dma_len !== 9'd0) begin
            n_fail++; $display("FAIL R10 len: %0d expected 0", dma_len);
        end
        n_tests++;
        rst_n = 1;
        @(negedge clk);

        // Receive watermark strictness
        fifo_count = 7;  chk(0, 0, 0, "R2 count equals rx wm");
        fifo_count = 8;  chk(1, 4, 0, "R2 count above rx wm");
        fifo_count = 0;  chk(1, 4, 0, "R6 held without ack");
        chk(1, 4, 0, "R6 still held");
        fifo_count = 8;  accept("R7 gap after ack");
        chk(1, 4, 0, "R7 re-evaluated after gap");
        accept("R7 gap");

        // Burst decode
        thr_cfg = cfg(3, 7, 8); fifo_count = 20;
        chk(1, 16, 0, "R1 code 3");
        accept("R1 ack");
        thr_cfg = cfg(0, 7, 8);
        chk(1, 1, 0, "R1 code 0");
        accept("R1 ack");
        thr_cfg = cfg(7, 7, 8); bytes_left = 2000;
        chk(1, 256, 0, "R1 code 7");
        accept("R1 ack");
        bytes_left = 400;
        chk(1, 100, 0, "R4 length limited to remaining words");
        accept("R4 ack");

        // Receive tail flush below watermark
        thr_cfg = cfg(1, 7, 8); bytes_left = 10; fifo_count = 3;
        chk(1, 3, 0, "R4 rx tail of rounded-up words");
        accept("R4 ack");
        fifo_count = 2;  chk(0, 0, 0, "R4 tail not yet in fifo");
        bytes_left = 0; fifo_count = 20;
        chk(0, 0, 0, "R5 rx nothing left");

        // Transmit watermark strictness
        dir_tx = 1; bytes_left = 400; fifo_count = 8;
        chk(0, 0, 0, "R3 count equals tx wm");
        fifo_count = 7;  chk(1, 4, 0, "R3 count below tx wm");
        accept("R3 ack");
        bytes_left = 8; fifo_count = 0;
        chk(1, 2, 0, "R4 tx tail length");
        accept("R4 ack");
        bytes_left = 0;  chk(0, 0, 0, "R5 tx nothing left");

        // Watermark clamp
        fifo_depth = 16; thr_cfg = cfg(1, 100, 100); bytes_left = 400;
        fifo_count = 15; chk(0, 0, 0, "R8 tx clamped wm equal");
        fifo_count = 14; chk(1, 4, 0, "R8 tx clamped wm below");
        accept("R8 ack");
        dir_tx = 0;
        fifo_count = 15; chk(0, 0, 0, "R8 rx clamped wm equal");
        fifo_count = 16; chk(1, 4, 0, "R8 rx clamped wm above");

        // Soft reset of FIFO pointers drops the pending request
        fifo_soft_rst = 1; chk(0, 0, 1, "R9 reset starts, request dropped");
        fifo_soft_rst = 0; chk(0, 0, 1, "R9 reset second cycle");
        chk(0, 0, 0, "R9 reset cleared itself");
        chk(1, 4, 0, "R9 request returns after reset");
        accept("R9 ack");

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule